// File: doc/BRIEF.md
# Pause Frame Request Scheduler

This block decides when a transmit MAC has to emit flow-control pause frames and which classes each frame carries. It serves nine channels. Channels 0 to 7 are per-priority classes. Channel 8 is the global (link-wide) pause. A channel is *active* while both its request and its enable input are high. The rising edge of activity makes the channel pending. While the channel stays active, a per-channel refresh counter makes it pending again after a programmable number of timer ticks. A one-cycle resend strobe marks every active channel pending at once and restarts all counters.

A three-state machine connects the pending set to the frame sender. In `ST_IDLE` nothing is eligible. In `ST_ARM` something is eligible, and the block waits for the sender to report an idle boundary between data packets. In `ST_SEND` the chosen channel vector is presented with a send strobe until the sender accepts it. The transitions are:
- IDLE→ARM when any channel is eligible.
- ARM→IDLE when nothing is eligible any longer.
- ARM→SEND when the idle boundary is seen.
- SEND→IDLE on accept.

A global pause always goes out alone and before any priority frame. All pending priority classes are merged into one frame. After acceptance, a transmitted pulse vector reports which channels went out. Building the frame bytes is left to the sender.

Top module: `pause_sched`

## Requirements
- R1: After reset, `send` is 0, `send_vec` is 0 and `sent` is 0.
- R2: A channel becomes pending on the cycle its request and enable are first both high, and a frame containing its bit (bit i = channel i, bit 8 = global) is later issued.
- R3: A channel whose enable is low is never issued or reported, whatever its request does.
- R4: `send` rises only after `tx_idle` was sampled high. It then stays high with `send_vec` unchanged until `tx_ack` is sampled high.
- R5: When channel 8 is eligible, the issued vector is exactly 0x100 (global alone), ahead of any pending priority channel.
- R6: Without a global pause, the issued vector has bit i set for every eligible priority channel 0..7, merged into one frame.
- R7: On the cycle after `send` and `tx_ack` are both high, `sent` equals the issued vector for one cycle; otherwise `sent` is 0.
- R8: While a channel stays active, its counter is loaded from its interval when it is raised or accepted. It counts down once per `tick`, and at the tick that finds it at 1 or 0 it makes the channel pending again and reloads. Intervals 0 and 1 both mean every tick.
- R9: A `resend` pulse makes every active channel pending and reloads every active counter. It overrides a same-cycle acceptance.
- R10: When a channel becomes inactive, its pending state and counter clear, and it is not issued again until it is re-raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 9 | Per-channel pause request level (bit 8 global) |
| en | input | 9 | Per-channel enable level |
| resend | input | 1 | One-cycle strobe: re-pend all active channels, restart timers |
| tick | input | 1 | Refresh timer step enable |
| refresh_ivl | input | 144 | Nine 16-bit refresh intervals, channel i at bits [16i+15:16i] |
| tx_idle | input | 1 | Sender is at an idle boundary between data packets |
| tx_ack | input | 1 | Sender accepts the presented pause frame |
| send | output | 1 | Pause frame request strobe, held until accepted |
| send_vec | output | 9 | Channel vector of the presented frame (0 when not sending) |
| sent | output | 9 | One-cycle per-channel transmitted pulse |

## Verification
The bench targets several corner cases:
- A global and priority requests raised in the same cycle. A design that merged them would show 0x122 instead of 0x100 followed by 0x022.
- A request that drops while it waits for an idle boundary. A design that forgot to clear it would issue a stale frame.
- A resend that lands on the acceptance cycle of the same channel. Giving the acceptance priority would lose the retransmission.
- Refresh intervals of 0 and 1. A counter that underflows would stall for 65536 ticks.

Random traffic stresses all of these cases against a cycle-level reference model, including enables that are held low and a sender that stalls its acceptance.

// File: rtl/pause_pkg.sv
package pause_pkg;
    localparam int unsigned NCH_DEF = 9;
    localparam int unsigned TW_DEF  = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_SEND = 2'd2
    } sched_st_t;
endpackage

// File: rtl/pause_chan.sv
// One refresh channel: pending flag plus countdown timer.
module pause_chan #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          resend,
    input  logic          tick,
    input  logic          clr,
    input  logic [TW-1:0] ivl,
    output logic          pend
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt;
    logic          act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            cnt   <= '0;
            act_q <= 1'b0;
        end else begin
            act_q <= act;
            if (!act) begin
                pend <= 1'b0;
                cnt  <= '0;
            end else if (resend || !act_q) begin
                pend <= 1'b1;
                cnt  <= ivl;
            end else if (clr) begin
                pend <= 1'b0;
                cnt  <= ivl;
            end else if (tick) begin
                if (cnt <= ONE) begin
                    pend <= 1'b1;
                    cnt  <= ivl;
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/pause_fsm.sv
// Issue state machine: waits for idle boundary, presents vector until accepted.
module pause_fsm
    import pause_pkg::*;
#(
    parameter int unsigned NCH = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] elig,
    input  logic           tx_idle,
    input  logic           tx_ack,
    output logic           send,
    output logic [NCH-1:0] send_vec,
    output logic [NCH-1:0] clr,
    output logic [NCH-1:0] sent
);
    localparam int unsigned GIDX = NCH - 1;
    localparam logic [NCH-1:0] GVEC = NCH'(1) << GIDX;

    sched_st_t      st, st_nx;
    logic [NCH-1:0] vec_q, pick;
    logic           any_elig, accept;

    always_comb begin
        if (elig[GIDX]) pick = GVEC;
        else            pick = elig & ~GVEC;
    end

    assign any_elig = |elig;
    assign accept   = (st == ST_SEND) && tx_ack;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (any_elig) st_nx = ST_ARM;
            ST_ARM: begin
                if (!any_elig)    st_nx = ST_IDLE;
                else if (tx_idle) st_nx = ST_SEND;
            end
            ST_SEND: if (tx_ack) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register plus the registered vector and status pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            vec_q <= '0;
            sent  <= '0;
        end else begin
            st   <= st_nx;
            sent <= accept ? vec_q : '0;
            if (st == ST_ARM && st_nx == ST_SEND) vec_q <= pick;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        send     = 1'b0;
        send_vec = '0;
        clr      = '0;
        unique case (st)
            ST_SEND: begin
                send     = 1'b1;
                send_vec = vec_q;
                clr      = tx_ack ? vec_q : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pause_sched.sv
module pause_sched
    import pause_pkg::*;
#(
    parameter int unsigned NCH = NCH_DEF,
    parameter int unsigned TW  = TW_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req,
    input  logic [NCH-1:0]    en,
    input  logic              resend,
    input  logic              tick,
    input  logic [NCH*TW-1:0] refresh_ivl,
    input  logic              tx_idle,
    input  logic              tx_ack,
    output logic              send,
    output logic [NCH-1:0]    send_vec,
    output logic [NCH-1:0]    sent
);
    logic [NCH-1:0] act, pend, clr;

    assign act = req & en;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        pause_chan #(.TW(TW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (act[i]),
            .resend(resend),
            .tick  (tick),
            .clr   (clr[i]),
            .ivl   (refresh_ivl[i*TW +: TW]),
            .pend  (pend[i])
        );
    end

    pause_fsm #(.NCH(NCH)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (pend & act),
        .tx_idle (tx_idle),
        .tx_ack  (tx_ack),
        .send    (send),
        .send_vec(send_vec),
        .clr     (clr),
        .sent    (sent)
    );
endmodule

// File: rtl/pause_sched_chk.sv
module pause_sched_chk #(
    parameter int unsigned NCH = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] req,
    input logic [NCH-1:0] en,
    input logic           tx_idle,
    input logic           tx_ack,
    input logic           send,
    input logic [NCH-1:0] send_vec,
    input logic [NCH-1:0] sent
);
    p_idle_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send) |-> $past(tx_idle));

    p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !tx_ack) |=> (send && $stable(send_vec)));

    p_global_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (send && send_vec[NCH-1]) |-> ($countones(send_vec) == 1));

    p_sent_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (send && tx_ack) |=> (sent == $past(send_vec)));

    p_sent_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sent != '0) |-> $past(send && tx_ack));

    p_enabled_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send) |-> ((send_vec & ~$past(req & en)) == '0));

    p_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        send |-> (send_vec != '0));
endmodule

bind pause_sched pause_sched_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .en      (en),
    .tx_idle (tx_idle),
    .tx_ack  (tx_ack),
    .send    (send),
    .send_vec(send_vec),
    .sent    (sent)
);

// File: tb/pause_sched_tb.sv
`timescale 1ns/1ps
module pause_sched_tb;
    localparam int NCH = 9;
    localparam int TW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    req = '0, en = '0;
    logic              resend = 1'b0, tick = 1'b0, tx_idle = 1'b0, tx_ack = 1'b0;
    logic [TW-1:0]     ivl [NCH];
    logic [NCH*TW-1:0] refresh_ivl;
    logic              send;
    logic [NCH-1:0]    send_vec, sent;

    int checks = 0, failures = 0, cyc = 0;
    string tag = "R1";

    always #10 clk = ~clk;  // 50 MHz

    always_comb
        for (int i = 0; i < NCH; i++) refresh_ivl[i*TW +: TW] = ivl[i];

    pause_sched u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .en(en), .resend(resend),
        .tick(tick), .refresh_ivl(refresh_ivl), .tx_idle(tx_idle),
        .tx_ack(tx_ack), .send(send), .send_vec(send_vec), .sent(sent)
    );

    // Reference model built from the requirements.
    logic [NCH-1:0] m_pend, m_actq, m_vec, m_sent;
    logic [TW-1:0]  m_cnt [NCH];
    int             m_st;

    function automatic logic [NCH-1:0] choose(input logic [NCH-1:0] e);
        if (e[8]) return 9'h100;
        return {1'b0, e[7:0]};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = '0; m_actq = '0; m_vec = '0; m_sent = '0; m_st = 0;
            for (int i = 0; i < NCH; i++) m_cnt[i] = '0;
        end else begin
            logic [NCH-1:0] a, e, c;
            a = req & en;
            e = m_pend & a;
            c = (m_st == 2 && tx_ack) ? m_vec : '0;
            m_sent = c;
            case (m_st)
                0: if (e != '0) m_st = 1;
                1: if (e == '0) m_st = 0;
                   else if (tx_idle) begin m_st = 2; m_vec = choose(e); end
                default: if (tx_ack) m_st = 0;
            endcase
            for (int i = 0; i < NCH; i++) begin
                if (!a[i]) begin m_pend[i] = 0; m_cnt[i] = '0; end
                else if (resend || !m_actq[i]) begin m_pend[i] = 1; m_cnt[i] = ivl[i]; end
                else if (c[i]) begin m_pend[i] = 0; m_cnt[i] = ivl[i]; end
                else if (tick) begin
                    if (m_cnt[i] <= 1) begin m_pend[i] = 1; m_cnt[i] = ivl[i]; end
                    else m_cnt[i] = m_cnt[i] - 1;
                end
            end
            m_actq = a;
        end
    end

    task automatic check(input logic ok, input string what, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act_v, exp_v);
        end
    endtask

    // Per-cycle comparison against the model, sampled at the falling edge.
    bit cmp_on = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            logic [NCH-1:0] ev;
            ev = (m_st == 2) ? m_vec : '0;
            check(send == (m_st == 2), "send", 32'(send), 32'(m_st == 2));
            check(send_vec == ev, "send_vec", 32'(send_vec), 32'(ev));
            check(sent == m_sent, "sent", 32'(sent), 32'(m_sent));
        end
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_send(input logic [NCH-1:0] exp, input string t);
        tag = t;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (send) begin
                check(send_vec == exp, "issued vector", 32'(send_vec), 32'(exp));
                tx_ack = 1'b1;
                @(negedge clk);
                tx_ack = 1'b0;
                return;
            end
        end
        check(1'b0, "no frame issued", 0, 32'(exp));
    endtask

    task automatic expect_quiet(input int n, input string t);
        int seen;
        tag = t;
        seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (send) seen++;
        end
        check(seen == 0, "unexpected frame", 32'(seen), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NCH; i++) ivl[i] = 16'd1000;
        step(3);
        tag = "R1";
        check(send == 0 && send_vec == '0 && sent == '0, "reset outputs", 32'({send, send_vec, sent}), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        en = '1;
        tx_idle = 1'b1;
        step(2);

        // R2: single priority channel
        req[3] = 1'b1;
        wait_send(9'h008, "R2");
        req[3] = 1'b0;
        step(2);

        // R5 then R6: global and two priorities raised together
        req = 9'h122;
        wait_send(9'h100, "R5");
        wait_send(9'h022, "R6");
        req = '0;
        step(2);

        // R3: requested but disabled
        en[2] = 1'b0;
        req[2] = 1'b1;
        expect_quiet(20, "R3");
        req[2] = 1'b0;
        en[2] = 1'b1;

        // R10: drop while waiting for an idle boundary
        tx_idle = 1'b0;
        req[4] = 1'b1;
        step(4);
        req[4] = 1'b0;
        step(1);
        tx_idle = 1'b1;
        expect_quiet(10, "R10");

        // R4: held until accepted
        req[6] = 1'b1;
        tag = "R4";
        step(6);
        check(send == 1'b1, "held send", 32'(send), 1);
        check(send_vec == 9'h040, "held vector", 32'(send_vec), 32'h40);
        tx_ack = 1'b1; step(1); tx_ack = 1'b0;
        tag = "R7";
        check(sent == 9'h040, "transmitted pulse", 32'(sent), 32'h40);
        step(1);
        check(sent == '0, "pulse width", 32'(sent), 0);

        // R9: resend re-issues an already-sent channel
        expect_quiet(8, "R9");
        resend = 1'b1; step(1); resend = 1'b0;
        wait_send(9'h040, "R9");
        req = '0;
        step(2);

        // R8: refresh with intervals 0 and 3
        ivl[0] = 16'd0;
        ivl[1] = 16'd3;
        tick = 1'b1;
        req[1] = 1'b1;
        wait_send(9'h002, "R8");
        wait_send(9'h002, "R8");
        req[1] = 1'b0;
        req[0] = 1'b1;
        wait_send(9'h001, "R8");
        wait_send(9'h001, "R8");
        req = '0;
        tick = 1'b0;
        step(3);

        // Random traffic compared cycle by cycle with the model.
        tag = "R8 R9 R6 random";
        for (int i = 0; i < NCH; i++) ivl[i] = 16'($urandom_range(0, 6));
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            if ($urandom_range(0, 15) == 0) req[$urandom_range(0, 8)] ^= 1'b1;
            if ($urandom_range(0, 40) == 0) en[$urandom_range(0, 8)] ^= 1'b1;
            tick    = ($urandom_range(0, 3) == 0);
            resend  = ($urandom_range(0, 60) == 0);
            tx_idle = ($urandom_range(0, 9) < 7);
            tx_ack  = ($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 500) == 0) ivl[$urandom_range(0, 8)] = 16'($urandom_range(0, 6));
        end
        @(negedge clk);
        resend = 0; tick = 0; tx_ack = 0;
        step(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule